// File: doc/BRIEF.md
# Ethernet Status LED Stretcher

This block drives two active-high indicator outputs from a network port's status and event signals. Each indicator has its own source selection and stretch setting. A source is either a level, such as link state, or an event that lasts one cycle, such as receive, transmit or combined activity. An indicator can also be forced on or forced off. A one-cycle event would be invisible on a lamp. The block therefore holds the output high for a chosen number of clock cycles after each event. A fresh event restarts the hold, so steady traffic keeps the lamp lit.

Three hold lengths are available. At the 25 MHz Ethernet clock they give about 40 ms, 70 ms and 140 ms. A fourth setting turns stretching off. The lengths are parameters: a test build can shrink them, and the behaviour stays the same. A global enable gates both outputs. Configuration arrives on plain input ports.

Top module: `led_status_stretcher`

## Requirements
- R1: While the active-low reset is asserted, both outputs are low and all hold counters are zero; after release they stay low until a source lights them.
- R2: When `led_en` is sampled low at a clock edge, both outputs are low after that edge and any running hold is cancelled, so no residue shows when the enable returns.
- R3: Mode field codes: 0 forces the output low, 1 forces it high, 2 selects link state, 3 receive events, 4 transmit events, 5 receive-or-transmit events; codes 6 and 7 behave as code 0.
- R4: In link mode the output equals `link_up` as sampled at the previous edge, whatever the stretch setting.
- R5: In an event mode, an event sampled at an edge drives the output high from that edge for exactly L cycles, where L is the selected hold length, and then low if no further event arrives.
- R6: Stretch field codes: 1 selects L = LEN_NORMAL (default 1,000,000 cycles), 2 selects LEN_MEDIUM (1,750,000), 3 selects LEN_LONG (3,500,000).
- R7: Stretch code 0 disables stretching: the output is the selected event delayed by one register, so it is high for one cycle per event.
- R8: An event that arrives while a hold is running restarts the full L-cycle hold from its own edge.
- R9: The two outputs are independent: each depends only on its own mode and stretch fields and on the shared inputs.
- R10: A hold counter never holds a value greater than the longest hold length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz Ethernet clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| led_en | input | 1 | Global enable for both indicators |
| mode_a | input | 3 | Source select for indicator A |
| stretch_a | input | 2 | Hold length select for indicator A |
| mode_b | input | 3 | Source select for indicator B |
| stretch_b | input | 2 | Hold length select for indicator B |
| link_up | input | 1 | Link state level |
| rx_pulse | input | 1 | One-cycle strobe per received frame |
| tx_pulse | input | 1 | One-cycle strobe per transmitted frame |
| led_a | output | 1 | Indicator A drive, high lights the lamp |
| led_b | output | 1 | Indicator B drive, high lights the lamp |

## Verification
The assertions assume that the configuration and strobe inputs are stable around the clock edge. They also assume that the stretch field does not change while a hold is running, because the counter takes the length only when it reloads. The bench changes inputs only on the falling edge. Before it changes a configuration, it parks both indicators in the off mode for one cycle, which clears every counter. It also shrinks the three lengths to 5, 9 and 17 cycles, so that every mode and stretch pair can be swept in full.

// File: rtl/led_stretch_pkg.sv
package led_stretch_pkg;

  typedef enum logic [2:0] {
    MD_OFF  = 3'd0,
    MD_ON   = 3'd1,
    MD_LINK = 3'd2,
    MD_RX   = 3'd3,
    MD_TX   = 3'd4,
    MD_ACT  = 3'd5
  } led_mode_e;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_NORMAL = 2'd1,
    ST_MEDIUM = 2'd2,
    ST_LONG   = 2'd3
  } led_stretch_e;

  // What the selected source asks the output stage to do
  typedef enum logic [1:0] {
    K_OFF   = 2'd0,
    K_ON    = 2'd1,
    K_LEVEL = 2'd2,
    K_EVENT = 2'd3
  } src_kind_e;

endpackage

// File: rtl/led_src_select.sv
module led_src_select
  import led_stretch_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       link_up,
  input  logic       rx_pulse,
  input  logic       tx_pulse,
  output src_kind_e  kind,
  output logic       val
);

  always_comb begin
    kind = K_OFF;
    val  = 1'b0;
    case (mode)
      MD_ON:   begin kind = K_ON;    val = 1'b1;                end
      MD_LINK: begin kind = K_LEVEL; val = link_up;             end
      MD_RX:   begin kind = K_EVENT; val = rx_pulse;            end
      MD_TX:   begin kind = K_EVENT; val = tx_pulse;            end
      MD_ACT:  begin kind = K_EVENT; val = rx_pulse | tx_pulse; end
      default: begin kind = K_OFF;   val = 1'b0;                end
    endcase
  end

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch
  import led_stretch_pkg::*;
#(
  parameter int unsigned LEN_NORMAL = 1000000,
  parameter int unsigned LEN_MEDIUM = 1750000,
  parameter int unsigned LEN_LONG   = 3500000,
  localparam int unsigned CW        = $clog2(LEN_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  src_kind_e  kind,
  input  logic       val,
  input  logic [1:0] stretch,
  output logic       led
);

  logic [CW-1:0] len;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          led_q, led_n;

  always_comb begin
    case (stretch)
      ST_NORMAL: len = CW'(LEN_NORMAL);
      ST_MEDIUM: len = CW'(LEN_MEDIUM);
      ST_LONG:   len = CW'(LEN_LONG);
      default:   len = CW'(1);
    endcase
  end

  // Next state
  always_comb begin
    cnt_n = '0;
    led_n = 1'b0;
    if (en) begin
      case (kind)
        K_ON:    led_n = 1'b1;
        K_LEVEL: led_n = val;
        K_EVENT: begin
          if (val) begin
            cnt_n = len;
            led_n = 1'b1;
          end else if (cnt_q != '0) begin
            cnt_n = cnt_q - CW'(1);
            led_n = (cnt_q > CW'(1));
          end
        end
        default: led_n = 1'b0;
      endcase
    end
  end

  assign cnt_en = (cnt_q != '0) | (kind == K_EVENT & val);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= 1'b0;
    end else begin
      led_q <= led_n;
    end
  end

  assign led = led_q;

  // R2
  off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !led_q);

  // R3
  force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == K_ON) |=> led_q);

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == K_LEVEL) |=> (led_q == $past(val)));

  // R5
  event_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == K_EVENT && val) |=> led_q);

  // R8
  reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == K_EVENT && val) |=> (cnt_q == $past(len)));

  // R10
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LEN_LONG));

endmodule

// File: rtl/led_status_stretcher.sv
module led_status_stretcher
  import led_stretch_pkg::*;
#(
  parameter int unsigned LEN_NORMAL = 1000000,
  parameter int unsigned LEN_MEDIUM = 1750000,
  parameter int unsigned LEN_LONG   = 3500000,
  localparam int unsigned NUM_LED   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       led_en,
  input  logic [2:0] mode_a,
  input  logic [1:0] stretch_a,
  input  logic [2:0] mode_b,
  input  logic [1:0] stretch_b,
  input  logic       link_up,
  input  logic       rx_pulse,
  input  logic       tx_pulse,
  output logic       led_a,
  output logic       led_b
);

  logic [2:0] mode_v    [NUM_LED];
  logic [1:0] stretch_v [NUM_LED];
  logic       led_v     [NUM_LED];

  assign mode_v[0]    = mode_a;
  assign mode_v[1]    = mode_b;
  assign stretch_v[0] = stretch_a;
  assign stretch_v[1] = stretch_b;

  for (genvar i = 0; i < NUM_LED; i++) begin : g_led
    src_kind_e kind;
    logic      val;

    led_src_select u_sel (
      .mode     (mode_v[i]),
      .link_up  (link_up),
      .rx_pulse (rx_pulse),
      .tx_pulse (tx_pulse),
      .kind     (kind),
      .val      (val)
    );

    led_pulse_stretch #(
      .LEN_NORMAL (LEN_NORMAL),
      .LEN_MEDIUM (LEN_MEDIUM),
      .LEN_LONG   (LEN_LONG)
    ) u_str (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (led_en),
      .kind    (kind),
      .val     (val),
      .stretch (stretch_v[i]),
      .led     (led_v[i])
    );
  end

  assign led_a = led_v[0];
  assign led_b = led_v[1];

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    !rst_n |-> (!led_a && !led_b));

endmodule

// File: tb/tb_led_status_stretcher.sv
module tb_led_status_stretcher;

  localparam int CLK_PERIOD = 40;
  localparam int L1 = 5;
  localparam int L2 = 9;
  localparam int L3 = 17;
  localparam int FAR = -1000000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       led_en;
  logic [2:0] mode_a, mode_b;
  logic [1:0] stretch_a, stretch_b;
  logic       link_up, rx_pulse, tx_pulse;
  logic       led_a, led_b;

  int n_cmp = 0;
  int n_bad = 0;
  int t = 0;
  int last_a = FAR;
  int last_b = FAR;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_status_stretcher #(.LEN_NORMAL(L1), .LEN_MEDIUM(L2), .LEN_LONG(L3)) dut (
    .clk(clk), .rst_n(rst_n), .led_en(led_en),
    .mode_a(mode_a), .stretch_a(stretch_a),
    .mode_b(mode_b), .stretch_b(stretch_b),
    .link_up(link_up), .rx_pulse(rx_pulse), .tx_pulse(tx_pulse),
    .led_a(led_a), .led_b(led_b)
  );

  function automatic int len_of(input logic [1:0] s);
    case (s)
      2'd1: return L1;
      2'd2: return L2;
      2'd3: return L3;
      default: return 1;
    endcase
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d got=%b exp=%b", tag, t, got, exp);
    end
  endtask

  // Expected output for one indicator after the coming edge
  task automatic predict(input logic [2:0] m, input logic [1:0] s, inout int last,
                         output logic e, output string tag);
    logic ev;
    ev = (m == 3'd3) ? rx_pulse : (m == 3'd4) ? tx_pulse :
         (m == 3'd5) ? (rx_pulse | tx_pulse) : 1'b0;
    if (!led_en) begin
      last = FAR; e = 1'b0; tag = "R2";
    end else if (m == 3'd1) begin
      last = FAR; e = 1'b1; tag = "R3";
    end else if (m == 3'd2) begin
      last = FAR; e = link_up; tag = "R4";
    end else if (m >= 3'd3 && m <= 3'd5) begin
      if (ev) last = t;
      e = ((t - last) < len_of(s));
      tag = (s == 2'd0) ? "R7" : "R5";
    end else begin
      last = FAR; e = 1'b0; tag = "R3";
    end
  endtask

  // Inputs already driven; advance one cycle and compare both outputs (R9)
  task automatic step();
    logic ea, eb;
    string ta, tb;
    predict(mode_a, stretch_a, last_a, ea, ta);
    predict(mode_b, stretch_b, last_b, eb, tb);
    @(posedge clk);
    @(negedge clk);
    check(led_a, ea, {ta, " A R9"});
    check(led_b, eb, {tb, " B R9"});
    t++;
  endtask

  task automatic park();
    mode_a = 3'd0; mode_b = 3'd0;
    rx_pulse = 0; tx_pulse = 0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; led_en = 1;
    mode_a = 3'd1; mode_b = 3'd1; stretch_a = 0; stretch_b = 0;
    link_up = 1; rx_pulse = 1; tx_pulse = 1;
    repeat (3) @(negedge clk);
    // R1: held in reset even with forced-on mode
    check(led_a, 1'b0, "R1 A");
    check(led_b, 1'b0, "R1 B");
    rst_n = 1;
    park();

    // Full sweep of mode x stretch for A; B gets the mirrored setting (R9)
    for (int ma = 0; ma < 8; ma++) begin
      for (int sa = 0; sa < 4; sa++) begin
        park();
        mode_a = 3'(ma); stretch_a = 2'(sa);
        mode_b = 3'(7 - ma); stretch_b = 2'(3 - sa);
        for (int i = 0; i < 44; i++) begin
          // R8: back-to-back and closely spaced events restart the hold
          rx_pulse = (i % 7 == 2) || (i == 20) || (i == 21);
          tx_pulse = (i % 11 == 5) && (i < 30);
          link_up  = ((i / 3) % 2) == 1;
          step();
        end
      end
    end

    // R6: measured hold length per stretch code, one isolated event
    for (int s = 0; s < 4; s++) begin
      int hi;
      park();
      mode_a = 3'd4; stretch_a = 2'(s); mode_b = 3'd0;
      tx_pulse = 1; step(); tx_pulse = 0;
      hi = (led_a === 1'b1) ? 1 : 0;
      for (int i = 0; i < 25; i++) begin
        step();
        if (led_a === 1'b1) hi++;
      end
      // R10: the hold never outlasts its selected length
      check(hi == len_of(2'(s)), 1'b1, "R6 hold length");
    end

    // R2: enable dropped mid-hold cancels it
    park();
    mode_a = 3'd3; stretch_a = 2'd3; mode_b = 3'd5; stretch_b = 2'd1;
    for (int i = 0; i < 40; i++) begin
      rx_pulse = (i == 1) || (i == 11);
      tx_pulse = (i == 25);
      led_en   = !(i >= 6 && i <= 8) && (i != 11);
      step();
    end
    led_en = 1;

    // R1: reset during a hold clears it
    park();
    mode_a = 3'd5; stretch_a = 2'd3; mode_b = 3'd3; stretch_b = 2'd2;
    rx_pulse = 1; step(); rx_pulse = 0;
    step();
    rst_n = 0;
    #1;
    check(led_a, 1'b0, "R1 async A");
    check(led_b, 1'b0, "R1 async B");
    @(negedge clk);
    rst_n = 1;
    last_a = FAR; last_b = FAR;
    for (int i = 0; i < 6; i++) step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule